// File: doc/BRIEF.md
# USB Endpoint Status and Handshake Controller

This block keeps the 8-bit status word of one USB device endpoint. It also picks the handshake that the serial interface engine returns for each transaction on that endpoint. Decoded transaction events come in as single-cycle pulses:

- a valid SETUP;
- an OUT data packet stored into bank 0 or bank 1;
- a data CRC error that goes with an OUT packet;
- an IN token;
- completion of an IN packet. This means "sent" on isochronous endpoints and "acknowledged by the host" on the other types.

The endpoint type and a ping-pong enable come from configuration. Firmware writes the status word through a simple write strobe. The block answers each event in the same cycle with a handshake code and a zero-length-packet flag, and updates the status word on the next clock edge. A level interrupt request is raised while any interrupt-worthy flag is set and interrupts are enabled.

Each endpoint type follows its own rules:

- Isochronous endpoints never block on a full bank and never send a handshake. On these endpoints the stall-sent flag becomes a read-only CRC-error indicator.
- A SETUP on a control endpoint always succeeds. It wipes the rest of the status word, including a pending stall request.

At most one transaction event is assumed per cycle; a completion pulse may coincide with a firmware write.

Top module: `ep_status_ctrl`

## Requirements
- R1: After synchronous active-low reset, `stat_q` is 8'h00, `hs_code` is 0 (none), and `zlp` and `irq` are 0.
- R2: Status bit layout is bit7 direction, bit6 bank-1 received, bit5 stall request, bit4 transmit ready, bit3 stall-sent/CRC, bit2 SETUP received, bit1 bank-0 received, bit0 transmit complete. Handshake codes are 0 none, 1 ACK, 2 NAK, 3 STALL. Endpoint types are 0 control, 1 isochronous, 2 bulk, 3 interrupt. A good OUT packet on a non-isochronous endpoint whose target bank flag is clear gets ACK, and the bank flag is set on the next edge. The target is bank 1 (bit6) only when ping-pong is enabled and `out_bank` is 1; otherwise it is bank 0 (bit1).
- R3: A good OUT on a non-isochronous endpoint whose target bank flag is already set gets NAK and leaves the status word unchanged. With ping-pong disabled, `out_bank` has no effect.
- R4: On an isochronous endpoint, an OUT packet gets handshake 0. Its bank flag is set even if it is already set, and bit3 takes the value of `crc_err` for that packet.
- R5: A SETUP on a control endpoint gets ACK regardless of stall request or bank state, and the status word becomes 8'h04. A SETUP on any other type gets 0 and changes nothing.
- R6: On a non-isochronous endpoint with bit5 set, an IN token or a good OUT gets STALL, and bit3 is set on the next edge.
- R7: An IN token on a non-isochronous endpoint with bit4 clear gets NAK. With bit4 set it gets 0, because data is sent. On an isochronous endpoint it always gets 0.
- R8: `zlp` is 1 during an IN token exactly when bit4 is set, `tx_empty` is 1 and no STALL is chosen.
- R9: An IN completion pulse clears bit4 and sets bit0 on the next edge.
- R10: `irq` is `irq_en` AND (bit6 OR bit2 OR bit1 OR bit0 OR (bit3 on a non-isochronous endpoint)).
- R11: A firmware write loads `wr_data` into the status word, except that bit3 keeps its value on isochronous endpoints.
- R12: When a hardware event and a firmware write fall in the same cycle, the hardware result wins for each bit the event touches, and the write applies to the remaining bits.
- R13: An OUT with `crc_err` on a non-isochronous endpoint gets 0 and leaves the status word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ep_kind | input | 2 | Endpoint type (0 control, 1 iso, 2 bulk, 3 interrupt) |
| pingpong_en | input | 1 | Enables the second OUT bank |
| irq_en | input | 1 | Endpoint interrupt enable |
| tx_empty | input | 1 | Transmit FIFO holds no data |
| ev_setup | input | 1 | Valid SETUP received |
| ev_out | input | 1 | OUT data packet received |
| out_bank | input | 1 | Bank the OUT packet targets |
| crc_err | input | 1 | Received data had a CRC error |
| ev_in_token | input | 1 | IN token addressed to the endpoint |
| ev_in_done | input | 1 | IN packet sent (iso) or acknowledged (others) |
| wr_en | input | 1 | Firmware write strobe |
| wr_data | input | 8 | Firmware write value |
| stat_q | output | 8 | Status word |
| hs_code | output | 2 | Chosen handshake for the current event |
| zlp | output | 1 | Respond with a zero-length packet |
| irq | output | 1 | Endpoint interrupt request |

## Verification
The bench builds the block with its default `PINGPONG_CAP` of 1, so the second bank exists. This lets the bench show that bank 1 fills independently of bank 0, and also that turning the runtime ping-pong enable off folds bank-1 packets back onto bank 0. Each endpoint type is driven through its own task. Those tasks cover the isochronous read-only CRC flag and the missing handshakes, the stall path, and same-cycle collisions between firmware writes and hardware events.

// File: rtl/ep_status_pkg.sv
// Shared encodings for the endpoint status controller.
// Assumes: status word is 8 bits with fixed bit meanings listed below.
package ep_status_pkg;
    localparam int STAT_W = 8;

    localparam int B_DIR   = 7;
    localparam int B_RXB1  = 6;
    localparam int B_STREQ = 5;
    localparam int B_TXRDY = 4;
    localparam int B_STCRC = 3;
    localparam int B_SETUP = 2;
    localparam int B_RXB0  = 1;
    localparam int B_TXCMP = 0;

    localparam logic [STAT_W-1:0] SETUP_ONLY = 8'h04;

    typedef enum logic [1:0] {
        EP_CTRL = 2'd0,
        EP_ISO  = 2'd1,
        EP_BULK = 2'd2,
        EP_INTR = 2'd3
    } ep_kind_e;

    typedef enum logic [1:0] {
        HS_NONE  = 2'd0,
        HS_ACK   = 2'd1,
        HS_NAK   = 2'd2,
        HS_STALL = 2'd3
    } hs_e;
endpackage

// File: rtl/ep_hs_decide.sv
// Handshake decision for one transaction event.
// Purely combinational. It chooses the handshake and the zero-length
// flag, and tells the status register which hardware updates to apply.
// Assumes: at most one of ev_setup / ev_out / ev_in_token is high per
// cycle; if several are high, SETUP wins over OUT, and OUT wins over IN.
// clk/rst_n are used only by the embedded assertions.
module ep_hs_decide
    import ep_status_pkg::*;
#(
    parameter bit PINGPONG_CAP = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ep_kind,
    input  logic       pingpong_en,
    input  logic       tx_empty,
    input  logic       ev_setup,
    input  logic       ev_out,
    input  logic       out_bank,
    input  logic       crc_err,
    input  logic       ev_in_token,
    input  logic       rxb0_q,
    input  logic       rxb1_q,
    input  logic       streq_q,
    input  logic       txrdy_q,
    output logic [1:0] hs_code,
    output logic       zlp,
    output logic       setup_acc,
    output logic       out_store,
    output logic       store_bank,
    output logic       crc_upd,
    output logic       stall_sent
);
    logic is_iso;
    logic is_ctrl;
    logic bank_sel;
    logic bank_full;

    assign is_iso  = (ep_kind == EP_ISO);
    assign is_ctrl = (ep_kind == EP_CTRL);

    // Choose the target bank; without ping-pong support it is always bank 0.
    generate
        if (PINGPONG_CAP) begin : g_two_banks
            assign bank_sel = pingpong_en & out_bank;
        end else begin : g_one_bank
            assign bank_sel = 1'b0;
        end
    endgenerate

    assign bank_full  = bank_sel ? rxb1_q : rxb0_q;
    assign store_bank = bank_sel;

    // Per-event handshake choice and hardware update requests.
    always_comb begin
        hs_code    = HS_NONE;
        zlp        = 1'b0;
        setup_acc  = 1'b0;
        out_store  = 1'b0;
        crc_upd    = 1'b0;
        stall_sent = 1'b0;
        if (ev_setup) begin
            if (is_ctrl) begin
                hs_code   = HS_ACK;
                setup_acc = 1'b1;
            end
        end else if (ev_out) begin
            if (is_iso) begin
                out_store = 1'b1;
                crc_upd   = 1'b1;
            end else if (crc_err) begin
                hs_code = HS_NONE;
            end else if (streq_q) begin
                hs_code    = HS_STALL;
                stall_sent = 1'b1;
            end else if (bank_full) begin
                hs_code = HS_NAK;
            end else begin
                hs_code   = HS_ACK;
                out_store = 1'b1;
            end
        end else if (ev_in_token) begin
            if (is_iso) begin
                zlp = txrdy_q & tx_empty;
            end else if (streq_q) begin
                hs_code    = HS_STALL;
                stall_sent = 1'b1;
            end else if (!txrdy_q) begin
                hs_code = HS_NAK;
            end else begin
                zlp = tx_empty;
            end
        end
    end

    // R3: a NAK never stores data
    a_r3_nak_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_code == HS_NAK) |-> !out_store);
    // R6: pending stall request answers an IN token with STALL
    a_r6_stall_in: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_in_token && !ev_setup && !ev_out && streq_q && !is_iso) |-> (hs_code == HS_STALL));
    // R4: isochronous endpoints never produce a handshake
    a_r4_iso_silent: assert property (@(posedge clk) disable iff (!rst_n)
        is_iso |-> (hs_code == HS_NONE));
    // R8: zero-length flag only while transmit ready
    a_r8_zlp_needs_txrdy: assert property (@(posedge clk) disable iff (!rst_n)
        zlp |-> (txrdy_q && tx_empty && ev_in_token));
endmodule

// File: rtl/ep_stat_reg.sv
// Endpoint status register.
// Applies a firmware write first, then overrides per bit with hardware
// updates, so that the hardware wins each bit it touches.
// Assumes: update requests come from ep_hs_decide in the same cycle.
module ep_stat_reg
    import ep_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_iso,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    input  logic              setup_acc,
    input  logic              out_store,
    input  logic              store_bank,
    input  logic              crc_upd,
    input  logic              crc_err,
    input  logic              stall_sent,
    input  logic              in_done,
    output logic [STAT_W-1:0] stat_q
);
    logic [STAT_W-1:0] stat_d;

    // Next-state merge of firmware write and hardware events.
    always_comb begin
        stat_d = stat_q;
        if (wr_en) begin
            stat_d = wr_data;
            if (is_iso) stat_d[B_STCRC] = stat_q[B_STCRC];
        end
        if (setup_acc) begin
            stat_d = SETUP_ONLY;
        end else begin
            if (out_store) begin
                if (store_bank) stat_d[B_RXB1] = 1'b1;
                else            stat_d[B_RXB0] = 1'b1;
            end
            if (crc_upd)    stat_d[B_STCRC] = crc_err;
            if (stall_sent) stat_d[B_STCRC] = 1'b1;
            if (in_done) begin
                stat_d[B_TXRDY] = 1'b0;
                stat_d[B_TXCMP] = 1'b1;
            end
        end
    end

    // Status storage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    // R5: SETUP leaves only the SETUP flag
    a_r5_setup_clears: assert property (@(posedge clk) disable iff (!rst_n)
        setup_acc |=> (stat_q == SETUP_ONLY));
    // R9: completion clears transmit ready and sets transmit complete
    a_r9_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        (in_done && !setup_acc) |=> (!stat_q[B_TXRDY] && stat_q[B_TXCMP]));
    // R4: isochronous data updates the CRC flag
    a_r4_crc_follow: assert property (@(posedge clk) disable iff (!rst_n)
        crc_upd |=> (stat_q[B_STCRC] == $past(crc_err)));
    // R11: firmware cannot alter the CRC flag on isochronous endpoints
    a_r11_iso_crc_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (is_iso && !crc_upd && !stall_sent && !setup_acc) |=> $stable(stat_q[B_STCRC]));
endmodule

// File: rtl/ep_irq_gen.sv
// Endpoint interrupt request.
// Level output: high while enabled and any interrupt-worthy flag is set.
// Assumes: the stall/CRC flag counts only on non-isochronous endpoints.
module ep_irq_gen (
    input  logic irq_en,
    input  logic is_iso,
    input  logic rxb1,
    input  logic stcrc,
    input  logic setup,
    input  logic rxb0,
    input  logic txcmp,
    output logic irq
);
    logic any_flag;

    // Collect the flags that request service.
    always_comb begin
        any_flag = rxb1 | setup | rxb0 | txcmp | (stcrc & ~is_iso);
        irq      = irq_en & any_flag;
    end
endmodule

// File: rtl/ep_status_ctrl.sv
// Top: endpoint status word and handshake selection for one USB endpoint.
// Assumes: one-cycle event pulses from the serial interface engine.
// The handshake and zlp outputs are valid in the same cycle as the event.
module ep_status_ctrl
    import ep_status_pkg::*;
#(
    parameter bit PINGPONG_CAP = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ep_kind,
    input  logic       pingpong_en,
    input  logic       irq_en,
    input  logic       tx_empty,
    input  logic       ev_setup,
    input  logic       ev_out,
    input  logic       out_bank,
    input  logic       crc_err,
    input  logic       ev_in_token,
    input  logic       ev_in_done,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] stat_q,
    output logic [1:0] hs_code,
    output logic       zlp,
    output logic       irq
);
    logic setup_acc;
    logic out_store;
    logic store_bank;
    logic crc_upd;
    logic stall_sent;
    logic is_iso;

    assign is_iso = (ep_kind == EP_ISO);

    ep_hs_decide #(.PINGPONG_CAP(PINGPONG_CAP)) u_decide (
        .clk         (clk),
        .rst_n       (rst_n),
        .ep_kind     (ep_kind),
        .pingpong_en (pingpong_en),
        .tx_empty    (tx_empty),
        .ev_setup    (ev_setup),
        .ev_out      (ev_out),
        .out_bank    (out_bank),
        .crc_err     (crc_err),
        .ev_in_token (ev_in_token),
        .rxb0_q      (stat_q[B_RXB0]),
        .rxb1_q      (stat_q[B_RXB1]),
        .streq_q     (stat_q[B_STREQ]),
        .txrdy_q     (stat_q[B_TXRDY]),
        .hs_code     (hs_code),
        .zlp         (zlp),
        .setup_acc   (setup_acc),
        .out_store   (out_store),
        .store_bank  (store_bank),
        .crc_upd     (crc_upd),
        .stall_sent  (stall_sent)
    );

    ep_stat_reg u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .is_iso     (is_iso),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .setup_acc  (setup_acc),
        .out_store  (out_store),
        .store_bank (store_bank),
        .crc_upd    (crc_upd),
        .crc_err    (crc_err),
        .stall_sent (stall_sent),
        .in_done    (ev_in_done),
        .stat_q     (stat_q)
    );

    ep_irq_gen u_irq (
        .irq_en (irq_en),
        .is_iso (is_iso),
        .rxb1   (stat_q[B_RXB1]),
        .stcrc  (stat_q[B_STCRC]),
        .setup  (stat_q[B_SETUP]),
        .rxb0   (stat_q[B_RXB0]),
        .txcmp  (stat_q[B_TXCMP]),
        .irq    (irq)
    );

    // R10: no interrupt while disabled
    a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_en);
    // R6: a STALL chosen now shows as stall-sent next cycle
    a_r6_stall_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_code == HS_STALL) |=> stat_q[B_STCRC]);
    // R2: an ACKed OUT sets a bank flag
    a_r2_ack_sets_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_out && !ev_setup && hs_code == HS_ACK) |=> (stat_q[B_RXB0] || stat_q[B_RXB1]));
endmodule

// File: tb/ep_status_ctrl_bench.sv
// Directed bench for ep_status_ctrl: one task per scenario.
module ep_status_ctrl_bench;
    import ep_status_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ep_kind = EP_BULK;
    logic       pingpong_en = 1'b0;
    logic       irq_en = 1'b1;
    logic       tx_empty = 1'b0;
    logic       ev_setup = 1'b0;
    logic       ev_out = 1'b0;
    logic       out_bank = 1'b0;
    logic       crc_err = 1'b0;
    logic       ev_in_token = 1'b0;
    logic       ev_in_done = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] stat_q;
    logic [1:0] hs_code;
    logic       zlp;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ep_status_ctrl u_ep_status_ctrl (
        .clk(clk), .rst_n(rst_n), .ep_kind(ep_kind), .pingpong_en(pingpong_en),
        .irq_en(irq_en), .tx_empty(tx_empty), .ev_setup(ev_setup), .ev_out(ev_out),
        .out_bank(out_bank), .crc_err(crc_err), .ev_in_token(ev_in_token),
        .ev_in_done(ev_in_done), .wr_en(wr_en), .wr_data(wr_data),
        .stat_q(stat_q), .hs_code(hs_code), .zlp(zlp), .irq(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Clock edge, then clear all one-cycle strobes away from the edge.
    task automatic tick();
        @(posedge clk);
        #1;
        ev_setup = 0; ev_out = 0; ev_in_token = 0; ev_in_done = 0;
        wr_en = 0; crc_err = 0; out_bank = 0;
        #1;
    endtask

    task automatic fw_write(input logic [7:0] v);
        wr_en = 1; wr_data = v;
        tick();
    endtask

    task automatic t_reset();
        chk("R1 stat", stat_q, 8'h00);
        chk("R1 hs", {6'd0, hs_code}, 8'd0);
        chk("R1 zlp", {7'd0, zlp}, 8'd0);
        chk("R1 irq", {7'd0, irq}, 8'd0);
    endtask

    task automatic t_out_banks();
        ep_kind = EP_BULK; pingpong_en = 0; irq_en = 1;
        ev_out = 1; #1;
        chk("R2 ack bank0", {6'd0, hs_code}, 8'd1);
        tick();
        chk("R2 bank0 set", stat_q, 8'h02);
        chk("R10 irq on rx", {7'd0, irq}, 8'd1);
        ev_out = 1; #1;
        chk("R3 nak full", {6'd0, hs_code}, 8'd2);
        tick();
        chk("R3 unchanged", stat_q, 8'h02);
        ev_out = 1; out_bank = 1; #1;
        chk("R3 bank1 ignored without pingpong", {6'd0, hs_code}, 8'd2);
        tick();
        chk("R3 still unchanged", stat_q, 8'h02);
        pingpong_en = 1;
        ev_out = 1; out_bank = 1; #1;
        chk("R2 ack bank1", {6'd0, hs_code}, 8'd1);
        tick();
        chk("R2 bank1 set", stat_q, 8'h42);
        fw_write(8'h00);
        chk("R11 fw clear", stat_q, 8'h00);
        chk("R10 irq off", {7'd0, irq}, 8'd0);
        irq_en = 0;
        fw_write(8'h01);
        chk("R10 irq gated", {7'd0, irq}, 8'd0);
        irq_en = 1;
        fw_write(8'h00);
        pingpong_en = 0;
    endtask

    task automatic t_crc_bulk();
        ep_kind = EP_BULK;
        ev_out = 1; crc_err = 1; #1;
        chk("R13 no handshake", {6'd0, hs_code}, 8'd0);
        tick();
        chk("R13 unchanged", stat_q, 8'h00);
    endtask

    task automatic t_iso();
        ep_kind = EP_ISO;
        ev_out = 1; crc_err = 1; #1;
        chk("R4 iso no hs", {6'd0, hs_code}, 8'd0);
        tick();
        chk("R4 crc flag set", stat_q, 8'h0A);
        ev_out = 1; crc_err = 0; #1;
        chk("R4 iso full no nak", {6'd0, hs_code}, 8'd0);
        tick();
        chk("R4 crc flag cleared", stat_q, 8'h02);
        ev_out = 1; crc_err = 1;
        tick();
        fw_write(8'h00);
        chk("R11 iso crc read-only", stat_q, 8'h08);
        chk("R10 iso crc no irq", {7'd0, irq}, 8'd0);
        ev_in_token = 1; #1;
        chk("R7 iso in no hs", {6'd0, hs_code}, 8'd0);
        tick();
        ep_kind = EP_BULK;
        fw_write(8'h00);
        chk("R11 bulk clears flag", stat_q, 8'h00);
    endtask

    task automatic t_in();
        ep_kind = EP_INTR;
        ev_in_token = 1; #1;
        chk("R7 nak not ready", {6'd0, hs_code}, 8'd2);
        tick();
        fw_write(8'h10);
        chk("R11 txrdy written", stat_q, 8'h10);
        tx_empty = 1; ev_in_token = 1; #1;
        chk("R7 ready no hs", {6'd0, hs_code}, 8'd0);
        chk("R8 zlp", {7'd0, zlp}, 8'd1);
        tick();
        tx_empty = 0; ev_in_token = 1; #1;
        chk("R8 no zlp with data", {7'd0, zlp}, 8'd0);
        tick();
        ev_in_done = 1;
        tick();
        chk("R9 complete", stat_q, 8'h01);
        chk("R10 irq on complete", {7'd0, irq}, 8'd1);
        fw_write(8'h00);
    endtask

    task automatic t_stall();
        ep_kind = EP_BULK;
        fw_write(8'h20);
        tx_empty = 1;
        fw_write(8'h30);
        ev_in_token = 1; #1;
        chk("R6 stall in", {6'd0, hs_code}, 8'd3);
        chk("R8 no zlp on stall", {7'd0, zlp}, 8'd0);
        tick();
        tx_empty = 0;
        chk("R6 stall flag", stat_q, 8'h38);
        chk("R10 irq on stall", {7'd0, irq}, 8'd1);
        ev_out = 1; #1;
        chk("R6 stall out", {6'd0, hs_code}, 8'd3);
        tick();
        chk("R6 no store", stat_q, 8'h38);
        fw_write(8'h00);
    endtask

    task automatic t_setup();
        ep_kind = EP_CTRL;
        fw_write(8'hA2);
        ev_setup = 1; #1;
        chk("R5 setup ack", {6'd0, hs_code}, 8'd1);
        tick();
        chk("R5 only setup flag", stat_q, 8'h04);
        ep_kind = EP_BULK;
        fw_write(8'h00);
        ev_setup = 1; #1;
        chk("R5 non-control no hs", {6'd0, hs_code}, 8'd0);
        tick();
        chk("R5 non-control unchanged", stat_q, 8'h00);
    endtask

    task automatic t_prio();
        ep_kind = EP_BULK;
        wr_en = 1; wr_data = 8'h80; ev_out = 1;
        tick();
        chk("R12 out wins bank0", stat_q, 8'h82);
        wr_en = 1; wr_data = 8'h10; ev_in_done = 1;
        tick();
        chk("R12 done wins txrdy", stat_q, 8'h01);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 t_reset();
        rst_n = 1;
        #2;
        t_out_banks();
        t_crc_bulk();
        t_iso();
        t_in();
        t_stall();
        t_setup();
        t_prio();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule